// File: doc/BRIEF.md
# DC-link balancing commutation selector

This block sits inside the modulator of a cascaded H-bridge converter with several cells in series. Once per sampling period it receives a start strobe, the measured capacitor voltage of every cell, the polarity of the AC line current, a normalized voltage demand `dv` and the present output level of each cell. It returns at most one commutation for that period. A commutation is made up of the index of the cell that switches, the level that cell moves to and the instant within the period at which it switches.

The reference for every cell is the mean of all measured capacitor voltages. The cell whose voltage lies furthest from that mean is tried first. A move is accepted only when the cell's present level, the sign of its voltage error and the sign of the line current together show that the move reduces the imbalance. If the move is refused, the next cell in the ranking is tried. If no cell qualifies, the block reports that no commutation takes place. Every move is to an adjacent level, so only one leg of one bridge changes per period. The result is held on the outputs and marked by a one-cycle done pulse.

Top module: `dclink_commit_sel`

## Requirements
- R1: The per-cell error is `floor(sum of all cell voltages / NCELL)` minus that cell's voltage. A negative error has sign "negative". A zero error counts as non-negative, exactly like a zero line current. `cur_neg`=1 means the line current is negative.
- R2: Cells are tried in order of decreasing absolute error. When two absolute errors are equal, the lower cell index is tried first.
- R3: Cell levels are encoded as 2'b11 = -1, 2'b00 = 0 and 2'b01 = +1. When dv>0 and the tried cell is at -1, it moves to 0 with instant 0, but only if its error sign equals the current sign.
- R4: When dv>0 and the tried cell is at 0, it moves to +1 at the computed instant, but only if its error sign equals the current sign.
- R5: When dv>0 and the tried cell is at +1, it moves to 0 at the computed instant, but only if dv<1.0 and its error sign differs from the current sign.
- R6: When dv<0 and the tried cell is at +1, it moves to 0 with instant 0, but only if its error sign differs from the current sign.
- R7: When dv<0 and the tried cell is at 0, it moves to -1 at the computed instant, but only if its error sign differs from the current sign.
- R8: When dv<0 and the tried cell is at -1, it moves to 0 at the computed instant, but only if dv>-1.0 and its error sign equals the current sign.
- R9: The first permitted cell in the ranking is the only one reported. If no cell is permitted, or if dv is 0, `no_cmd` is 1 and `cmd_cell`, `cmd_state` and `cmd_instant` are 0. A reported level is always adjacent to, and different from, the cell's present level.
- R10: `dv` is two's complement with FRAC fractional bits. The computed instant is `floor(period * (2^FRAC - |dv|) / 2^FRAC)` when |dv| < 1.0, and 0 otherwise. It therefore never exceeds `period`.
- R11: After reset, `done`, `no_cmd`, `cmd_cell`, `cmd_state` and `cmd_instant` are 0. After a start strobe, `done` pulses high for exactly one cycle within 16 clock cycles. The results stay unchanged until the next start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin one period's selection; sampled only while idle |
| v_cell | input | NCELL*VW | Capacitor voltages, cell i in bits [i*VW +: VW], unsigned |
| cur_neg | input | 1 | 1 when the line current is negative |
| dv | input | DVW | Normalized voltage demand, signed, FRAC fractional bits |
| cell_st | input | 2*NCELL | Present level of each cell, cell i in bits [2i +: 2] |
| period | input | PW | Sampling period length in instant ticks |
| done | output | 1 | One-cycle pulse when the result is valid |
| no_cmd | output | 1 | No cell switches this period |
| cmd_cell | output | IW | Index of the cell that switches |
| cmd_state | output | 2 | Level the chosen cell moves to |
| cmd_instant | output | PW | Switching instant within the period |

## Verification
The hardest case to reach from the ports is the one where the top-ranked cells are refused and a lower-ranked cell is accepted. This includes the case in which every cell is refused. Reaching it needs a specific combination of voltage spread, cell levels, current sign and dv sign. The directed cases place the voltages so that the ranking is known in advance, including exact ties. They then set the levels and the current sign so that the first one or two candidates fail their sign rule. The random phase draws voltages from a narrow band and draws the other inputs evenly, so that refusals, fall-through and no-commutation outcomes all occur often. The clamp of the instant is driven directly with |dv| equal to 1.0 and with |dv| just below it.

// File: rtl/dcb_pkg.sv
// Shared encodings for the DC-link balancing commutation selector.
// Assumes two-bit cell levels in two's complement; 2'b10 is never driven.
package dcb_pkg;
    typedef enum logic [1:0] {
        CS_ZERO = 2'b00,
        CS_POS  = 2'b01,
        CS_NEG  = 2'b11
    } cell_lvl_t;

    typedef enum logic [1:0] {
        FS_IDLE = 2'b00,
        FS_RANK = 2'b01,
        FS_TRY  = 2'b10
    } sel_fsm_t;
endpackage

// File: rtl/dcb_err_rank.sv
// Computes the mean of all cell voltages, the signed error of each cell
// against it, and the trial order by decreasing absolute error (ties go to
// the lower index). Purely combinational; assumes unsigned voltage inputs.
module dcb_err_rank #(
    parameter int NCELL = 3,
    parameter int VW    = 12,
    parameter int IW    = 2
) (
    input  logic [NCELL*VW-1:0] v,
    output logic [NCELL*IW-1:0] order,
    output logic [NCELL-1:0]    err_neg
);
    localparam int SW = VW + $clog2(NCELL);
    localparam int EW = VW + 2;

    logic [SW-1:0]        sum;
    logic [VW-1:0]        mean;
    logic signed [EW-1:0] err [NCELL];
    logic [EW-1:0]        mag [NCELL];
    logic [IW-1:0]        rk  [NCELL];

    // Sum of every cell voltage.
    always_comb begin
        sum = '0;
        for (int i = 0; i < NCELL; i++) begin
            sum = sum + SW'(v[i*VW +: VW]);
        end
        mean = VW'(sum / SW'(NCELL));
    end

    // Per-cell signed error and its magnitude.
    for (genvar g = 0; g < NCELL; g++) begin : g_err
        assign err[g]     = $signed({2'b00, mean}) - $signed({2'b00, v[g*VW +: VW]});
        assign err_neg[g] = err[g][EW-1];
        assign mag[g]     = err[g][EW-1] ? EW'(-err[g]) : EW'(err[g]);
    end

    // Rank of each cell: how many cells precede it in the trial order.
    always_comb begin
        for (int i = 0; i < NCELL; i++) begin
            rk[i] = '0;
            for (int j = 0; j < NCELL; j++) begin
                if (j != i && (mag[j] > mag[i] || (mag[j] == mag[i] && j < i))) begin
                    rk[i] = rk[i] + IW'(1);
                end
            end
        end
    end

    // Invert ranks into the trial order list.
    always_comb begin
        order = '0;
        for (int r = 0; r < NCELL; r++) begin
            for (int i = 0; i < NCELL; i++) begin
                if (rk[i] == IW'(r)) begin
                    order[r*IW +: IW] = IW'(i);
                end
            end
        end
    end
endmodule

// File: rtl/dcb_permit.sv
// Decides whether one candidate cell may switch given its level, the sign of
// its voltage error, the sign of the line current and dv; gives the target
// level and the switching instant. Combinational; assumes DVW > FRAC + 1.
module dcb_permit
    import dcb_pkg::*;
#(
    parameter int DVW  = 12,
    parameter int FRAC = 8,
    parameter int PW   = 16
) (
    input  logic [1:0]           lvl,
    input  logic                 err_neg,
    input  logic                 cur_neg,
    input  logic signed [DVW-1:0] dv,
    input  logic [PW-1:0]        period,
    output logic                 ok,
    output logic [1:0]           nxt,
    output logic [PW-1:0]        inst
);
    localparam int          FW    = FRAC + 1;
    localparam int          MW    = PW + FW;
    localparam logic [DVW:0] ONE_W = (DVW+1)'(1) << FRAC;

    logic signed [DVW:0] dvx;
    logic [DVW:0]        mag;
    logic                ge1;
    logic                same;
    logic                dv_pos;
    logic                dv_neg;
    logic [FW-1:0]       frac;
    logic [PW-1:0]       calc;

    // Magnitude of dv and the scaled instant, zero once |dv| reaches 1.0.
    always_comb begin
        dvx  = {dv[DVW-1], dv};
        mag  = dvx[DVW] ? unsigned'(-dvx) : unsigned'(dvx);
        ge1  = (mag >= ONE_W);
        frac = ge1 ? '0 : FW'(ONE_W - mag);
        calc = PW'(({{FW{1'b0}}, period} * {{PW{1'b0}}, frac}) >> FRAC);
        if (ge1) calc = '0;
    end

    // Sign-based permission table for both polarities of dv.
    always_comb begin
        same   = (err_neg == cur_neg);
        dv_neg = dv[DVW-1];
        dv_pos = !dv_neg && (dv != '0);
        ok     = 1'b0;
        nxt    = CS_ZERO;
        inst   = '0;
        if (dv_pos) begin
            unique case (lvl)
                CS_NEG:  begin ok = same;         nxt = CS_ZERO; inst = '0;   end
                CS_ZERO: begin ok = same;         nxt = CS_POS;  inst = calc; end
                CS_POS:  begin ok = !same && !ge1; nxt = CS_ZERO; inst = calc; end
                default: ok = 1'b0;
            endcase
        end else if (dv_neg) begin
            unique case (lvl)
                CS_POS:  begin ok = !same;        nxt = CS_ZERO; inst = '0;   end
                CS_ZERO: begin ok = !same;        nxt = CS_NEG;  inst = calc; end
                CS_NEG:  begin ok = same && !ge1; nxt = CS_ZERO; inst = calc; end
                default: ok = 1'b0;
            endcase
        end
    end
endmodule

// File: rtl/dclink_commit_sel.sv
// Per-period commutation selector: captures inputs on start, ranks cells by
// absolute DC-link error, then tries one candidate per cycle until one is
// permitted or all are refused. Holds the result and pulses done.
// Assumes start is only raised while idle; it is ignored otherwise.
module dclink_commit_sel
    import dcb_pkg::*;
#(
    parameter int NCELL = 3,
    parameter int VW    = 12,
    parameter int DVW   = 12,
    parameter int FRAC  = 8,
    parameter int PW    = 16,
    localparam int IW   = (NCELL > 1) ? $clog2(NCELL) : 1
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  start,
    input  logic [NCELL*VW-1:0]   v_cell,
    input  logic                  cur_neg,
    input  logic signed [DVW-1:0] dv,
    input  logic [2*NCELL-1:0]    cell_st,
    input  logic [PW-1:0]         period,
    output logic                  done,
    output logic                  no_cmd,
    output logic [IW-1:0]         cmd_cell,
    output logic [1:0]            cmd_state,
    output logic [PW-1:0]         cmd_instant
);
    sel_fsm_t              fsm_q;
    logic [NCELL*VW-1:0]   v_q;
    logic [2*NCELL-1:0]    st_q;
    logic                  cur_q;
    logic signed [DVW-1:0] dv_q;
    logic [PW-1:0]         per_q;
    logic [NCELL*IW-1:0]   ord_q;
    logic [NCELL-1:0]      eneg_q;
    logic [IW-1:0]         idx_q;

    logic [NCELL*IW-1:0]   order_c;
    logic [NCELL-1:0]      eneg_c;
    logic [IW-1:0]         sel;
    logic                  ok_c;
    logic [1:0]            nxt_c;
    logic [PW-1:0]         inst_c;

    dcb_err_rank #(.NCELL(NCELL), .VW(VW), .IW(IW)) rank_i (
        .v       (v_q),
        .order   (order_c),
        .err_neg (eneg_c)
    );

    // Candidate under trial this cycle.
    assign sel = ord_q[idx_q*IW +: IW];

    dcb_permit #(.DVW(DVW), .FRAC(FRAC), .PW(PW)) permit_i (
        .lvl     (st_q[sel*2 +: 2]),
        .err_neg (eneg_q[sel]),
        .cur_neg (cur_q),
        .dv      (dv_q),
        .period  (per_q),
        .ok      (ok_c),
        .nxt     (nxt_c),
        .inst    (inst_c)
    );

    // Sequencer: capture, rank, then walk the ranking one cell per cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fsm_q       <= FS_IDLE;
            v_q         <= '0;
            st_q        <= '0;
            cur_q       <= 1'b0;
            dv_q        <= '0;
            per_q       <= '0;
            ord_q       <= '0;
            eneg_q      <= '0;
            idx_q       <= '0;
            done        <= 1'b0;
            no_cmd      <= 1'b0;
            cmd_cell    <= '0;
            cmd_state   <= '0;
            cmd_instant <= '0;
        end else begin
            done <= 1'b0;
            unique case (fsm_q)
                FS_IDLE: begin
                    if (start) begin
                        v_q   <= v_cell;
                        st_q  <= cell_st;
                        cur_q <= cur_neg;
                        dv_q  <= dv;
                        per_q <= period;
                        fsm_q <= FS_RANK;
                    end
                end
                FS_RANK: begin
                    ord_q  <= order_c;
                    eneg_q <= eneg_c;
                    idx_q  <= '0;
                    fsm_q  <= FS_TRY;
                end
                FS_TRY: begin
                    if (ok_c) begin
                        done        <= 1'b1;
                        no_cmd      <= 1'b0;
                        cmd_cell    <= sel;
                        cmd_state   <= nxt_c;
                        cmd_instant <= inst_c;
                        fsm_q       <= FS_IDLE;
                    end else if (idx_q == IW'(NCELL-1)) begin
                        done        <= 1'b1;
                        no_cmd      <= 1'b1;
                        cmd_cell    <= '0;
                        cmd_state   <= '0;
                        cmd_instant <= '0;
                        fsm_q       <= FS_IDLE;
                    end else begin
                        idx_q <= idx_q + IW'(1);
                    end
                end
                default: fsm_q <= FS_IDLE;
            endcase
        end
    end

    // ---------------- assertions ----------------
    logic [4:0]       lat_q;
    logic [NCELL-1:0] seen;
    logic [1:0]       old_lvl;

    // Busy-cycle counter used only by the latency check.
    always_ff @(posedge clk) begin
        if (!rst_n || fsm_q == FS_IDLE) lat_q <= '0;
        else if (lat_q != 5'd31)         lat_q <= lat_q + 5'd1;
    end

    // Which cells appear in the stored trial order.
    always_comb begin
        seen = '0;
        for (int r = 0; r < NCELL; r++) begin
            for (int i = 0; i < NCELL; i++) begin
                if (ord_q[r*IW +: IW] == IW'(i)) seen[i] = 1'b1;
            end
        end
    end

    assign old_lvl = st_q[cmd_cell*2 +: 2];

    assert_done_pulse_R11: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_latency_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q != FS_IDLE) |-> (lat_q < 5'd15));

    assert_order_complete_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FS_TRY) |-> ($countones(seen) == NCELL));

    assert_adjacent_level_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_cmd) |-> ((cmd_state != old_lvl) &&
            !(cmd_state == CS_POS && old_lvl == CS_NEG) &&
            !(cmd_state == CS_NEG && old_lvl == CS_POS)));

    assert_instant_range_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !no_cmd) |-> (cmd_instant <= per_q));

    assert_held_result_R11: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q == FS_IDLE && !$past(done) && !done) |-> ($stable(cmd_instant) && $stable(no_cmd)));
endmodule

// File: tb/dclink_commit_sel_tb.sv
`timescale 1ns/1ps
module dclink_commit_sel_tb_top;
    localparam int NCELL = 3;
    localparam int VW    = 12;
    localparam int DVW   = 12;
    localparam int FRAC  = 8;
    localparam int PW    = 16;
    localparam int IW    = 2;

    logic                  clk = 1'b0;
    logic                  rst_n = 1'b0;
    logic                  start = 1'b0;
    logic [NCELL*VW-1:0]   v_cell = '0;
    logic                  cur_neg = 1'b0;
    logic signed [DVW-1:0] dv = '0;
    logic [2*NCELL-1:0]    cell_st = '0;
    logic [PW-1:0]         period = '0;
    logic                  done;
    logic                  no_cmd;
    logic [IW-1:0]         cmd_cell;
    logic [1:0]            cmd_state;
    logic [PW-1:0]         cmd_instant;

    int total = 0;
    int bad   = 0;

    always #2 clk = ~clk;

    dclink_commit_sel #(.NCELL(NCELL), .VW(VW), .DVW(DVW), .FRAC(FRAC), .PW(PW)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .v_cell(v_cell), .cur_neg(cur_neg),
        .dv(dv), .cell_st(cell_st), .period(period), .done(done), .no_cmd(no_cmd),
        .cmd_cell(cmd_cell), .cmd_state(cmd_state), .cmd_instant(cmd_instant)
    );

    // Level code to integer.
    function automatic int lvl_int(input logic [1:0] c);
        return (c == 2'b01) ? 1 : (c == 2'b11) ? -1 : 0;
    endfunction

    // Computed instant per R10.
    function automatic int inst_of(input int d, input int per);
        int m;
        m = (d < 0) ? -d : d;
        if (m >= 256) return 0;
        return (per * (256 - m)) / 256;
    endfunction

    // Reference model: returns {no, cell[1:0], level[1:0], instant[15:0]}.
    function automatic logic [20:0] model(input int v0, input int v1, input int v2,
                                          input logic [5:0] st, input bit cn,
                                          input int d, input int per);
        int vv[3]; int e[3]; int mg[3]; int ord[3]; bit used[3];
        int mean, best, c, lv;
        bit en, same, ok;
        logic [1:0] nx; int ins;
        vv[0] = v0; vv[1] = v1; vv[2] = v2;
        mean = (v0 + v1 + v2) / 3;
        for (int i = 0; i < 3; i++) begin
            e[i] = mean - vv[i]; mg[i] = (e[i] < 0) ? -e[i] : e[i]; used[i] = 0;
        end
        for (int r = 0; r < 3; r++) begin
            best = -1;
            for (int i = 0; i < 3; i++)
                if (!used[i] && (best < 0 || mg[i] > mg[best])) best = i;
            ord[r] = best; used[best] = 1;
        end
        for (int r = 0; r < 3; r++) begin
            c = ord[r]; lv = lvl_int(st[c*2 +: 2]);
            en = (e[c] < 0); same = (en == cn); ok = 0; nx = 2'b00; ins = 0;
            if (d > 0) begin
                if (lv == -1)     begin ok = same; ins = 0; end
                else if (lv == 0) begin ok = same; nx = 2'b01; ins = inst_of(d, per); end
                else              begin ok = !same && d < 256; ins = inst_of(d, per); end
            end else if (d < 0) begin
                if (lv == 1)      begin ok = !same; ins = 0; end
                else if (lv == 0) begin ok = !same; nx = 2'b11; ins = inst_of(d, per); end
                else              begin ok = same && d > -256; ins = inst_of(d, per); end
            end
            if (ok) return {1'b0, 2'(c), nx, 16'(ins)};
        end
        return {1'b1, 2'b00, 2'b00, 16'd0};
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // Apply one period and compare with the model.
    task automatic run(input string tag, input int v0, input int v1, input int v2,
                       input logic [5:0] st, input bit cn, input int d, input int per);
        logic [20:0] ex;
        int cnt;
        ex = model(v0, v1, v2, st, cn, d, per);
        @(negedge clk);
        v_cell  = {VW'(v2), VW'(v1), VW'(v0)};
        cell_st = st; cur_neg = cn; dv = DVW'(d); period = PW'(per);
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        cnt = 1;
        while (!done && cnt < 20) begin
            @(negedge clk); cnt++;
        end
        chk({tag, " R11 done latency"}, (done && cnt <= 16) ? 1 : 0, 1);
        chk({tag, " R9 no_cmd"}, no_cmd, int'(ex[20]));
        chk({tag, " R2 cell"}, cmd_cell, int'(ex[19:18]));
        chk({tag, " R9 level"}, cmd_state, int'(ex[17:16]));
        chk({tag, " R10 instant"}, cmd_instant, int'(ex[15:0]));
        @(negedge clk);
        chk({tag, " R11 done single"}, done, 0);
        chk({tag, " R11 held"}, cmd_instant, int'(ex[15:0]));
    endtask

    function automatic logic [1:0] rlvl();
        int k;
        k = $urandom % 3;
        return (k == 0) ? 2'b11 : (k == 1) ? 2'b00 : 2'b01;
    endfunction

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        chk("R11 reset done", done, 0);
        chk("R11 reset no_cmd", no_cmd, 0);
        chk("R11 reset cell", cmd_cell, 0);
        chk("R11 reset level", cmd_state, 0);
        chk("R11 reset instant", cmd_instant, 0);
        rst_n = 1'b1;

        // Cell2 has error -67 (neg), ranked first.
        run("R3 dvpos from -1",  1000, 1000, 1100, 6'b11_00_00, 1'b1,  100, 1000);
        run("R4 dvpos from 0",   1000, 1000, 1100, 6'b00_01_01, 1'b1,  64, 1000);
        run("R4 clamp dv=1.0",   1000, 1000, 1100, 6'b00_01_01, 1'b1,  256, 1000);
        run("R5 dvpos from +1",  1000, 1000, 1100, 6'b01_00_00, 1'b0,  255, 4000);
        run("R5 blocked dv>=1",  1000, 1000, 1100, 6'b01_01_01, 1'b0,  300, 4000);
        run("R6 dvneg from +1",  1000, 1000, 1100, 6'b01_00_00, 1'b0, -50, 1000);
        run("R7 dvneg from 0",   1000, 1000, 1100, 6'b00_01_01, 1'b0, -128, 999);
        run("R8 dvneg from -1",  1000, 1000, 1100, 6'b11_01_01, 1'b1, -255, 777);
        run("R8 blocked dv<=-1", 1000, 1000, 1100, 6'b11_11_11, 1'b1, -256, 777);
        // Tie: cells 0 and 1 equal, cell1 must lose to cell0.
        run("R2 tie low index",  1100, 1100, 1000, 6'b00_00_00, 1'b1,  80, 500);
        run("R2 tie fallthrough",1100, 1100, 1000, 6'b00_00_11, 1'b0,  80, 500);
        // All equal: all errors zero (non-negative), current zero -> positive.
        run("R1 zero error",     1500, 1500, 1500, 6'b00_00_00, 1'b0,  40, 800);
        run("R9 none permitted", 1500, 1500, 1500, 6'b00_00_00, 1'b1,  40, 800);
        run("R9 dv zero",        1000, 1200, 1100, 6'b00_00_00, 1'b0,  0, 800);
        run("R1 floor mean",     1000, 1001, 1001, 6'b00_00_00, 1'b1,  10, 300);

        for (int n = 0; n < 400; n++) begin
            int b;
            b = 1000 + ($urandom % 2000);
            run("random R1 R2 R9", b + ($urandom % 64), b + ($urandom % 64), b + ($urandom % 64),
                {rlvl(), rlvl(), rlvl()}, 1'($urandom % 2),
                int'($urandom % 801) - 400, int'($urandom % 65536));
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (150000) @(posedge clk);
        total++; bad++;
        $display("FAIL R11 watchdog actual=hung expected=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule